// File: doc/BRIEF.md
# CCD Readout Timing Sequencer

This block produces the raster timing that paces an interline CCD whose horizontal register is clocked at 18 MHz. It counts pixel clocks within a line and lines within a frame. It pulses a line marker on the first clock of every line and holds a frame marker for the whole of line 1. Four readout modes are supported: full-resolution readout, the decimated fast readout, and two autofocus window modes. Each of them runs with either NTSC or PAL frame timing. Selected lines in each frame are shorter than the rest, so that the frame period lands exactly on the target rate.

In the two autofocus modes the block also schedules two bursts. The first is a top burst that moves a programmable number of rows, 0 to 255. The second is a fixed bottom burst that sweeps away the rest of the picture. While these run, the block tells the downstream pixel path which row of the decimated image each later line carries and whether that row is usable. In full-resolution mode it schedules a clearing sweep at a fixed place in the frame. The mode, the standard and the shift count are sampled only at the frame boundary, so a change on the inputs never corrupts the frame in progress.

All pins are plain control and status signals; there is no streamed data path and no back-pressure.

Top module: `ccd_drive_seq`

## Requirements
- R1: Reset sets the pixel count and the line count to 1, with the line and frame markers high. The active configuration becomes full readout, NTSC, shift 0. The first frame after reset runs with that configuration whatever the inputs say.
- R2: The pixel count runs 1, 2, … up to the length of the current line and then returns to 1. `hd` is high exactly when the pixel count is 1. A normal line lasts LINE_CLKS clocks (default 2288).
- R3: The line count advances by one at each line start and wraps from the frame's last line to 1. `vd` is high for every clock of line 1 and at no other time.
- R4: Full readout with NTSC has FR_N_LINES lines (default 1838). Lines FR_N_SHORT_A and FR_N_SHORT_B (defaults 919, 1828) last FR_N_SHORT_CLKS clocks (default 1716).
- R5: Full readout with PAL has FR_P_LINES lines (default 1890). Lines FR_P_SHORT_A, FR_P_SHORT_A+1, and the last two lines of the frame (defaults 944, 945, 1889, 1890) last FR_P_SHORT_CLKS clocks (default 1208).
- R6: Fast readout has HF_N_LINES lines with NTSC (defaults 263, last line 1144 clocks) and HF_P_LINES lines with PAL (defaults 315, last line 1568 clocks). In both, only the last line is shortened.
- R7: The AF1 and AF2 modes shorten only the last line. AF1 has 132 lines with a 572-clock last line (NTSC) or 158 lines with a 784-clock last line (PAL). AF2 has 66 lines with a 1430-clock last line (NTSC) or 79 lines with a 1536-clock last line (PAL), which makes 180000 clocks. All of these are defaults.
- R8: `mode_sel` (0 full, 1 fast, 2 AF1, 3 AF2), `pal_sel` (0 NTSC, 1 PAL) and `shift_sel` take effect only on the clock edge that wraps from the last clock of the last line to line 1. At that edge they appear on `mode_active`, `pal_active` and `shift_lines`.
- R9: In AF1 and AF2, `fshift_active` is high on lines SHIFT_FIRST through SHIFT_FIRST+SHIFT_LEN-1 (defaults 6 to 18, 13 line times). In the other modes it stays low.
- R10: `sweep_active` is high on the SWEEP_LEN lines that follow the shift window. SWEEP_LEN is A1_SWEEP_LEN in AF1 (default 7) and A2_SWEEP_LEN in AF2 (default 11). In full readout it is high on FR_SWEEP_LEN lines from FR_SWEEP_FIRST (defaults 27 lines from line 810).
- R11: The output window opens on the line after the sweep ends: line 26 in AF1 and line 30 in AF2 with the defaults. Two lines before that opening line, `out_row` equals shift+1, and it then rises by one per line. `row_valid` is high only from the opening line through the frame's second-to-last line while `out_row` ≤ MAX_ROW (default 258). So rows shift+1 and shift+2 are never valid.
- R12: In fast readout, `fshift_active`, `sweep_active` and `row_valid` stay low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested readout mode (0 full, 1 fast, 2 AF1, 3 AF2) |
| pal_sel | input | 1 | Requested standard (0 NTSC, 1 PAL) |
| shift_sel | input | SHIFT_W | Requested top shift count |
| pix_cnt | output | PIX_W | Pixel position in the line, from 1 |
| line_cnt | output | LINE_W | Line position in the frame, from 1 |
| hd | output | 1 | Line start marker |
| vd | output | 1 | Frame marker, high during line 1 |
| mode_active | output | 2 | Mode of the current frame |
| pal_active | output | 1 | Standard of the current frame |
| shift_lines | output | SHIFT_W | Shift count of the current frame |
| fshift_active | output | 1 | Top frame-shift burst in progress |
| sweep_active | output | 1 | High-speed sweep burst in progress |
| out_row | output | ROW_W | Decimated-image row carried by this line |
| row_valid | output | 1 | This line carries a usable row |

## Verification
The bench scales the geometry down to keep frames short. It uses 16-clock lines and frames of 9 to 22 lines, with shortened lines of 4 to 12 clocks placed both inside the frame and at its end. It uses a 3-line shift window, sweeps of 2 and 3 lines, and a row ceiling of 12. With these values every mode and standard fits in a few hundred clocks. Per-line lengths, burst positions and complete row windows can then be checked line by line. Shift counts can push the window into the ceiling: partly, down to a single valid row, or entirely out of range. Mid-frame configuration changes and a mid-frame reset are also reached in a few frames.

// File: rtl/ccd_seq_pkg.sv
`timescale 1ns/1ps
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_HFR  = 2'd1,
    MODE_AF1  = 2'd2,
    MODE_AF2  = 2'd3
  } rd_mode_e;

  typedef struct packed {
    rd_mode_e mode;
    logic     pal;
  } frame_fmt_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_cfg_latch.sv
`timescale 1ns/1ps
module ccd_cfg_latch
  import ccd_seq_pkg::*;
#(
  parameter int SHIFT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         mode_in,
  input  logic               pal_in,
  input  logic [SHIFT_W-1:0] shift_in,
  output frame_fmt_t         fmt_q,
  output logic [SHIFT_W-1:0] shift_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q.mode <= MODE_FULL;
      fmt_q.pal  <= 1'b0;
      shift_q    <= '0;
    end else if (load) begin
      fmt_q.mode <= rd_mode_e'(mode_in);
      fmt_q.pal  <= pal_in;
      shift_q    <= shift_in;
    end
  end

endmodule

// File: rtl/ccd_line_len.sv
`timescale 1ns/1ps
module ccd_line_len
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W           = 12,
  parameter int LINE_W          = 11,
  parameter int LINE_CLKS       = 2288,
  parameter int FR_N_LINES      = 1838,
  parameter int FR_N_SHORT_A    = 919,
  parameter int FR_N_SHORT_B    = 1828,
  parameter int FR_N_SHORT_CLKS = 1716,
  parameter int FR_P_LINES      = 1890,
  parameter int FR_P_SHORT_A    = 944,
  parameter int FR_P_SHORT_CLKS = 1208,
  parameter int HF_N_LINES      = 263,
  parameter int HF_N_LAST       = 1144,
  parameter int HF_P_LINES      = 315,
  parameter int HF_P_LAST       = 1568,
  parameter int A1_N_LINES      = 132,
  parameter int A1_N_LAST       = 572,
  parameter int A1_P_LINES      = 158,
  parameter int A1_P_LAST       = 784,
  parameter int A2_N_LINES      = 66,
  parameter int A2_N_LAST       = 1430,
  parameter int A2_P_LINES      = 79,
  parameter int A2_P_LAST       = 1536
) (
  input  frame_fmt_t        fmt,
  input  logic [LINE_W-1:0] line,
  output logic [LINE_W-1:0] frame_lines,
  output logic [PIX_W-1:0]  line_clks
);

  localparam logic [PIX_W-1:0]  C_NORM  = PIX_W'(LINE_CLKS);
  localparam logic [LINE_W-1:0] N_FR_N  = LINE_W'(FR_N_LINES);
  localparam logic [LINE_W-1:0] S_FR_NA = LINE_W'(FR_N_SHORT_A);
  localparam logic [LINE_W-1:0] S_FR_NB = LINE_W'(FR_N_SHORT_B);
  localparam logic [PIX_W-1:0]  C_FR_N  = PIX_W'(FR_N_SHORT_CLKS);
  localparam logic [LINE_W-1:0] N_FR_P  = LINE_W'(FR_P_LINES);
  localparam logic [LINE_W-1:0] N_FR_P1 = LINE_W'(FR_P_LINES - 1);
  localparam logic [LINE_W-1:0] S_FR_PA = LINE_W'(FR_P_SHORT_A);
  localparam logic [LINE_W-1:0] S_FR_PB = LINE_W'(FR_P_SHORT_A + 1);
  localparam logic [PIX_W-1:0]  C_FR_P  = PIX_W'(FR_P_SHORT_CLKS);
  localparam logic [LINE_W-1:0] N_HF_N  = LINE_W'(HF_N_LINES);
  localparam logic [PIX_W-1:0]  C_HF_N  = PIX_W'(HF_N_LAST);
  localparam logic [LINE_W-1:0] N_HF_P  = LINE_W'(HF_P_LINES);
  localparam logic [PIX_W-1:0]  C_HF_P  = PIX_W'(HF_P_LAST);
  localparam logic [LINE_W-1:0] N_A1_N  = LINE_W'(A1_N_LINES);
  localparam logic [PIX_W-1:0]  C_A1_N  = PIX_W'(A1_N_LAST);
  localparam logic [LINE_W-1:0] N_A1_P  = LINE_W'(A1_P_LINES);
  localparam logic [PIX_W-1:0]  C_A1_P  = PIX_W'(A1_P_LAST);
  localparam logic [LINE_W-1:0] N_A2_N  = LINE_W'(A2_N_LINES);
  localparam logic [PIX_W-1:0]  C_A2_N  = PIX_W'(A2_N_LAST);
  localparam logic [LINE_W-1:0] N_A2_P  = LINE_W'(A2_P_LINES);
  localparam logic [PIX_W-1:0]  C_A2_P  = PIX_W'(A2_P_LAST);

  logic             short_hit;
  logic [PIX_W-1:0] short_clks;

  // Full readout shortens lines inside the frame; all other modes trim only the final line.
  always_comb begin
    frame_lines = N_FR_N;
    short_hit   = 1'b0;
    short_clks  = C_NORM;
    case (fmt.mode)
      MODE_FULL: begin
        if (!fmt.pal) begin
          frame_lines = N_FR_N;
          short_hit   = (line == S_FR_NA) || (line == S_FR_NB);
          short_clks  = C_FR_N;
        end else begin
          frame_lines = N_FR_P;
          short_hit   = (line == S_FR_PA) || (line == S_FR_PB) ||
                        (line == N_FR_P1) || (line == N_FR_P);
          short_clks  = C_FR_P;
        end
      end
      MODE_HFR: begin
        frame_lines = fmt.pal ? N_HF_P : N_HF_N;
        short_clks  = fmt.pal ? C_HF_P : C_HF_N;
        short_hit   = (line == frame_lines);
      end
      MODE_AF1: begin
        frame_lines = fmt.pal ? N_A1_P : N_A1_N;
        short_clks  = fmt.pal ? C_A1_P : C_A1_N;
        short_hit   = (line == frame_lines);
      end
      MODE_AF2: begin
        frame_lines = fmt.pal ? N_A2_P : N_A2_N;
        short_clks  = fmt.pal ? C_A2_P : C_A2_N;
        short_hit   = (line == frame_lines);
      end
      default: ;
    endcase
    line_clks = short_hit ? short_clks : C_NORM;
  end

endmodule

// File: rtl/ccd_raster_cnt.sv
`timescale 1ns/1ps
module ccd_raster_cnt #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  line_clks,
  input  logic [LINE_W-1:0] frame_lines,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LINE_W-1:0] line_q,
  output logic              frame_end
);

  logic line_end;

  assign line_end  = (pix_q == line_clks);
  assign frame_end = line_end && (line_q == frame_lines);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= PIX_W'(1);
      line_q <= LINE_W'(1);
    end else if (line_end) begin
      pix_q  <= PIX_W'(1);
      line_q <= frame_end ? LINE_W'(1) : line_q + LINE_W'(1);
    end else begin
      pix_q  <= pix_q + PIX_W'(1);
    end
  end

endmodule

// File: rtl/ccd_af_sched.sv
`timescale 1ns/1ps
module ccd_af_sched
  import ccd_seq_pkg::*;
#(
  parameter int LINE_W         = 11,
  parameter int SHIFT_W        = 8,
  parameter int ROW_W          = 12,
  parameter int SHIFT_FIRST    = 6,
  parameter int SHIFT_LEN      = 13,
  parameter int A1_SWEEP_LEN   = 7,
  parameter int A2_SWEEP_LEN   = 11,
  parameter int FR_SWEEP_FIRST = 810,
  parameter int FR_SWEEP_LEN   = 27,
  parameter int MAX_ROW        = 258
) (
  input  frame_fmt_t         fmt,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [LINE_W-1:0]  line,
  input  logic [LINE_W-1:0]  frame_lines,
  output logic               fshift_active,
  output logic               sweep_active,
  output logic [ROW_W-1:0]   out_row,
  output logic               row_valid
);

  localparam int SWEEP_BASE = SHIFT_FIRST + SHIFT_LEN;
  localparam logic [LINE_W-1:0] L_SH_FIRST = LINE_W'(SHIFT_FIRST);
  localparam logic [LINE_W-1:0] L_SH_LAST  = LINE_W'(SWEEP_BASE - 1);
  localparam logic [LINE_W-1:0] L_SW_FIRST = LINE_W'(SWEEP_BASE);
  localparam logic [LINE_W-1:0] L_FR_FIRST = LINE_W'(FR_SWEEP_FIRST);
  localparam logic [LINE_W-1:0] L_FR_LAST  = LINE_W'(FR_SWEEP_FIRST + FR_SWEEP_LEN - 1);
  localparam logic [ROW_W-1:0]  R_CEIL     = ROW_W'(MAX_ROW);

  logic [LINE_W-1:0] sw_last  [2];
  logic [LINE_W-1:0] win_open [2];
  logic [LINE_W-1:0] pre_line [2];

  // One window geometry per autofocus variant, differing only in sweep length.
  for (genvar g = 0; g < 2; g++) begin : g_af
    localparam int SW_LEN = (g == 0) ? A1_SWEEP_LEN : A2_SWEEP_LEN;
    assign sw_last[g]  = LINE_W'(SWEEP_BASE + SW_LEN - 1);
    assign win_open[g] = LINE_W'(SWEEP_BASE + SW_LEN);
    assign pre_line[g] = LINE_W'(SWEEP_BASE + SW_LEN - 2);
  end

  logic is_af, sel, in_stream;
  logic [ROW_W-1:0] row_calc;

  assign is_af = (fmt.mode == MODE_AF1) || (fmt.mode == MODE_AF2);
  assign sel   = (fmt.mode == MODE_AF2);

  assign fshift_active = is_af && (line >= L_SH_FIRST) && (line <= L_SH_LAST);

  assign sweep_active = (is_af && (line >= L_SW_FIRST) && (line <= sw_last[sel])) ||
                        ((fmt.mode == MODE_FULL) && (line >= L_FR_FIRST) && (line <= L_FR_LAST));

  // Row shift+1 sits two lines ahead of the window opening; one row per line after that.
  assign in_stream = is_af && (line >= pre_line[sel]);
  assign row_calc  = ROW_W'(shift) + ROW_W'(1) + ROW_W'(line) - ROW_W'(pre_line[sel]);
  assign out_row   = in_stream ? row_calc : '0;

  assign row_valid = is_af && (line >= win_open[sel]) && (line < frame_lines) &&
                     (row_calc <= R_CEIL);

endmodule

// File: rtl/ccd_drive_seq.sv
`timescale 1ns/1ps
module ccd_drive_seq
  import ccd_seq_pkg::*;
#(
  parameter int LINE_CLKS       = 2288,
  parameter int FR_N_LINES      = 1838,
  parameter int FR_N_SHORT_A    = 919,
  parameter int FR_N_SHORT_B    = 1828,
  parameter int FR_N_SHORT_CLKS = 1716,
  parameter int FR_P_LINES      = 1890,
  parameter int FR_P_SHORT_A    = 944,
  parameter int FR_P_SHORT_CLKS = 1208,
  parameter int HF_N_LINES      = 263,
  parameter int HF_N_LAST       = 1144,
  parameter int HF_P_LINES      = 315,
  parameter int HF_P_LAST       = 1568,
  parameter int A1_N_LINES      = 132,
  parameter int A1_N_LAST       = 572,
  parameter int A1_P_LINES      = 158,
  parameter int A1_P_LAST       = 784,
  parameter int A2_N_LINES      = 66,
  parameter int A2_N_LAST       = 1430,
  parameter int A2_P_LINES      = 79,
  parameter int A2_P_LAST       = 1536,
  parameter int SHIFT_FIRST     = 6,
  parameter int SHIFT_LEN       = 13,
  parameter int A1_SWEEP_LEN    = 7,
  parameter int A2_SWEEP_LEN    = 11,
  parameter int FR_SWEEP_FIRST  = 810,
  parameter int FR_SWEEP_LEN    = 27,
  parameter int MAX_ROW         = 258,
  parameter int SHIFT_W         = 8,
  localparam int MAX_LINES = max2(max2(max2(FR_N_LINES, FR_P_LINES), max2(HF_N_LINES, HF_P_LINES)),
                                  max2(max2(A1_N_LINES, A1_P_LINES), max2(A2_N_LINES, A2_P_LINES))),
  localparam int PIX_W  = $clog2(LINE_CLKS + 1),
  localparam int LINE_W = $clog2(MAX_LINES + 1),
  localparam int ROW_W  = $clog2((1 << SHIFT_W) + MAX_LINES + 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               pal_sel,
  input  logic [SHIFT_W-1:0] shift_sel,
  output logic [PIX_W-1:0]   pix_cnt,
  output logic [LINE_W-1:0]  line_cnt,
  output logic               hd,
  output logic               vd,
  output logic [1:0]         mode_active,
  output logic               pal_active,
  output logic [SHIFT_W-1:0] shift_lines,
  output logic               fshift_active,
  output logic               sweep_active,
  output logic [ROW_W-1:0]   out_row,
  output logic               row_valid
);

  frame_fmt_t        fmt_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [LINE_W-1:0] frame_lines;
  logic [PIX_W-1:0]  line_clks;
  logic              frame_end;

  ccd_cfg_latch #(.SHIFT_W(SHIFT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_end),
    .mode_in  (mode_sel),
    .pal_in   (pal_sel),
    .shift_in (shift_sel),
    .fmt_q    (fmt_q),
    .shift_q  (shift_q)
  );

  ccd_line_len #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .LINE_CLKS(LINE_CLKS),
    .FR_N_LINES(FR_N_LINES), .FR_N_SHORT_A(FR_N_SHORT_A), .FR_N_SHORT_B(FR_N_SHORT_B),
    .FR_N_SHORT_CLKS(FR_N_SHORT_CLKS), .FR_P_LINES(FR_P_LINES), .FR_P_SHORT_A(FR_P_SHORT_A),
    .FR_P_SHORT_CLKS(FR_P_SHORT_CLKS), .HF_N_LINES(HF_N_LINES), .HF_N_LAST(HF_N_LAST),
    .HF_P_LINES(HF_P_LINES), .HF_P_LAST(HF_P_LAST), .A1_N_LINES(A1_N_LINES),
    .A1_N_LAST(A1_N_LAST), .A1_P_LINES(A1_P_LINES), .A1_P_LAST(A1_P_LAST),
    .A2_N_LINES(A2_N_LINES), .A2_N_LAST(A2_N_LAST), .A2_P_LINES(A2_P_LINES),
    .A2_P_LAST(A2_P_LAST)
  ) u_len (
    .fmt         (fmt_q),
    .line        (line_cnt),
    .frame_lines (frame_lines),
    .line_clks   (line_clks)
  );

  ccd_raster_cnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_clks   (line_clks),
    .frame_lines (frame_lines),
    .pix_q       (pix_cnt),
    .line_q      (line_cnt),
    .frame_end   (frame_end)
  );

  ccd_af_sched #(
    .LINE_W(LINE_W), .SHIFT_W(SHIFT_W), .ROW_W(ROW_W),
    .SHIFT_FIRST(SHIFT_FIRST), .SHIFT_LEN(SHIFT_LEN),
    .A1_SWEEP_LEN(A1_SWEEP_LEN), .A2_SWEEP_LEN(A2_SWEEP_LEN),
    .FR_SWEEP_FIRST(FR_SWEEP_FIRST), .FR_SWEEP_LEN(FR_SWEEP_LEN),
    .MAX_ROW(MAX_ROW)
  ) u_af (
    .fmt           (fmt_q),
    .shift         (shift_q),
    .line          (line_cnt),
    .frame_lines   (frame_lines),
    .fshift_active (fshift_active),
    .sweep_active  (sweep_active),
    .out_row       (out_row),
    .row_valid     (row_valid)
  );

  assign hd          = (pix_cnt == PIX_W'(1));
  assign vd          = (line_cnt == LINE_W'(1));
  assign mode_active = fmt_q.mode;
  assign pal_active  = fmt_q.pal;
  assign shift_lines = shift_q;

endmodule

// File: rtl/ccd_drive_seq_chk.sv
`timescale 1ns/1ps
module ccd_drive_seq_chk #(
  parameter int PIX_W   = 12,
  parameter int LINE_W  = 11,
  parameter int ROW_W   = 12,
  parameter int SHIFT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PIX_W-1:0]   pix_cnt,
  input logic [LINE_W-1:0]  line_cnt,
  input logic               hd,
  input logic               vd,
  input logic [SHIFT_W-1:0] shift_lines,
  input logic               fshift_active,
  input logic               sweep_active,
  input logic [ROW_W-1:0]   out_row,
  input logic               row_valid
);

  a_r2_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != PIX_W'(1)) |-> (pix_cnt == $past(pix_cnt) + PIX_W'(1)));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hd && line_cnt != LINE_W'(1)) |-> (line_cnt == $past(line_cnt) + LINE_W'(1)));

  a_r3_frame_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vd) |-> hd);

  a_r8_shift_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shift_lines) |-> (hd && vd));

  a_r10_bursts_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(fshift_active && sweep_active));

  a_r11_valid_outside_bursts: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> !(fshift_active || sweep_active));

  a_r11_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && hd && $past(row_valid)) |-> (out_row == $past(out_row) + ROW_W'(1)));

endmodule

bind ccd_drive_seq ccd_drive_seq_chk #(
  .PIX_W(PIX_W), .LINE_W(LINE_W), .ROW_W(ROW_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pix_cnt       (pix_cnt),
  .line_cnt      (line_cnt),
  .hd            (hd),
  .vd            (vd),
  .shift_lines   (shift_lines),
  .fshift_active (fshift_active),
  .sweep_active  (sweep_active),
  .out_row       (out_row),
  .row_valid     (row_valid)
);

// File: tb/tb_ccd_drive_seq.sv
`timescale 1ns/1ps
module tb_ccd_drive_seq;

  localparam int LC = 16;
  localparam int SHW = 8;
  localparam int PW = $clog2(LC + 1);
  localparam int LW = $clog2(22 + 1);
  localparam int RW = $clog2((1 << SHW) + 22 + 4);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd3;
  logic pal_sel = 1'b1;
  logic [SHW-1:0] shift_sel = 8'd5;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;
  logic hd, vd, pal_active, fshift_active, sweep_active, row_valid;
  logic [1:0] mode_active;
  logic [SHW-1:0] shift_lines;
  logic [RW-1:0] out_row;

  always #10 clk = ~clk;

  ccd_drive_seq #(
    .LINE_CLKS(LC), .FR_N_LINES(20), .FR_N_SHORT_A(7), .FR_N_SHORT_B(18), .FR_N_SHORT_CLKS(12),
    .FR_P_LINES(22), .FR_P_SHORT_A(9), .FR_P_SHORT_CLKS(10),
    .HF_N_LINES(9), .HF_N_LAST(8), .HF_P_LINES(11), .HF_P_LAST(12),
    .A1_N_LINES(14), .A1_N_LAST(4), .A1_P_LINES(16), .A1_P_LAST(6),
    .A2_N_LINES(12), .A2_N_LAST(10), .A2_P_LINES(13), .A2_P_LAST(9),
    .SHIFT_FIRST(2), .SHIFT_LEN(3), .A1_SWEEP_LEN(2), .A2_SWEEP_LEN(3),
    .FR_SWEEP_FIRST(3), .FR_SWEEP_LEN(2), .MAX_ROW(12), .SHIFT_W(SHW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pal_sel(pal_sel), .shift_sel(shift_sel),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .hd(hd), .vd(vd), .mode_active(mode_active),
    .pal_active(pal_active), .shift_lines(shift_lines), .fshift_active(fshift_active),
    .sweep_active(sweep_active), .out_row(out_row), .row_valid(row_valid)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        pal;
    logic [7:0]  shift;
    int          clocks;
    int          lines;
    int          sh_lines;
    int          sw_lines;
    int          n_valid;
    int          first_row;
  } vec_t;

  // mode, pal, shift | frame clocks, lines, shift lines, sweep lines, valid rows, first valid row
  localparam vec_t VECS [0:8] = '{
    '{2'd0, 1'b0, 8'd0,  312, 20, 0, 2, 0, 0},
    '{2'd0, 1'b1, 8'd0,  328, 22, 0, 2, 0, 0},
    '{2'd1, 1'b0, 8'd0,  136,  9, 0, 0, 0, 0},
    '{2'd1, 1'b1, 8'd0,  172, 11, 0, 0, 0, 0},
    '{2'd2, 1'b0, 8'd0,  212, 14, 3, 2, 7, 3},
    '{2'd2, 1'b1, 8'd2,  246, 16, 3, 2, 8, 5},
    '{2'd3, 1'b0, 8'd1,  186, 12, 3, 3, 4, 4},
    '{2'd3, 1'b1, 8'd9,  201, 13, 3, 3, 1, 12},
    '{2'd2, 1'b0, 8'd10, 212, 14, 3, 2, 0, 0}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // measured frame statistics
  int m_clocks, m_lines, m_sh, m_sw, m_valid, m_first, m_vdclk, m_badhd, m_prerow;
  int m_len [0:31];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] m, input logic p, input int ln, input int nl);
    case (m)
      2'd0: if (!p) return (ln == 7 || ln == 18) ? 12 : 16;
            else    return (ln == 9 || ln == 10 || ln == 21 || ln == 22) ? 10 : 16;
      2'd1: return (ln == nl) ? (p ? 12 : 8) : 16;
      2'd2: return (ln == nl) ? (p ? 6 : 4) : 16;
      default: return (ln == nl) ? (p ? 9 : 10) : 16;
    endcase
  endfunction

  // Measure one frame; the caller is at the negedge of its first clock.
  task automatic measure(input int pre_line);
    m_clocks = 0; m_lines = 0; m_sh = 0; m_sw = 0; m_valid = 0; m_first = 0;
    m_vdclk = 0; m_badhd = 0; m_prerow = -1;
    for (int k = 0; k < 32; k++) m_len[k] = 0;
    do begin
      m_clocks++;
      m_len[line_cnt]++;
      if (hd != (pix_cnt == 1)) m_badhd++;
      if (vd) m_vdclk++;
      if (hd) begin
        m_lines++;
        if (fshift_active) m_sh++;
        if (sweep_active) m_sw++;
        if (row_valid) begin
          m_valid++;
          if (m_first == 0) m_first = int'(out_row);
        end
        if (int'(line_cnt) == pre_line) m_prerow = int'(out_row);
      end
      @(negedge clk);
    end while (!(pix_cnt == 1 && line_cnt == 1));
  endtask

  function automatic string len_tag(input logic [1:0] m, input logic p);
    if (m == 2'd0) return p ? "R5" : "R4";
    if (m == 2'd1) return "R6";
    return "R7";
  endfunction

  initial begin
    // R1: reset state, inputs requesting something else
    @(negedge clk); @(negedge clk);
    chk("R1", "pix_cnt in reset", int'(pix_cnt), 1);
    chk("R1", "line_cnt in reset", int'(line_cnt), 1);
    chk("R1", "hd/vd in reset", {30'd0, hd, vd}, 3);
    chk("R1", "mode/pal/shift in reset", {mode_active, pal_active, shift_lines}, 0);
    chk("R1", "burst and valid flags in reset", {fshift_active, sweep_active, row_valid}, 0);
    rst_n = 1'b1;
    measure(-1);
    chk("R1", "first frame clocks use default config", m_clocks, 312);
    chk("R8", "config loaded at boundary", {mode_active, pal_active, shift_lines}, {2'd3, 1'b1, 8'd5});

    // table walk
    for (int v = 0; v < 9; v++) begin
      int pre, bad;
      string lt;
      vec_t x;
      x = VECS[v];
      lt = len_tag(x.mode, x.pal);
      mode_sel = x.mode; pal_sel = x.pal; shift_sel = x.shift;
      do @(negedge clk); while (!(pix_cnt == 1 && line_cnt == 1));
      pre = (x.mode == 2'd2) ? 5 : (x.mode == 2'd3) ? 6 : -1;
      measure(pre);
      chk(lt, $sformatf("vec %0d frame clocks", v), m_clocks, x.clocks);
      chk("R3", $sformatf("vec %0d lines", v), m_lines, x.lines);
      chk("R3", $sformatf("vec %0d vd clocks", v), m_vdclk, LC);
      chk("R2", $sformatf("vec %0d hd only on clock 1", v), m_badhd, 0);
      bad = 0;
      for (int ln = 1; ln <= x.lines; ln++)
        if (m_len[ln] != exp_len(x.mode, x.pal, ln, x.lines)) begin
          bad++;
          $display("FAIL %s vec %0d line %0d length: actual %0d expected %0d",
                   lt, v, ln, m_len[ln], exp_len(x.mode, x.pal, ln, x.lines));
        end
      chk(lt, $sformatf("vec %0d per-line lengths", v), bad, 0);
      chk((x.mode == 2'd1) ? "R12" : "R9", $sformatf("vec %0d shift lines", v), m_sh, x.sh_lines);
      chk((x.mode == 2'd1) ? "R12" : "R10", $sformatf("vec %0d sweep lines", v), m_sw, x.sw_lines);
      chk((x.mode == 2'd1) ? "R12" : "R11", $sformatf("vec %0d valid rows", v), m_valid, x.n_valid);
      chk("R11", $sformatf("vec %0d first valid row", v), m_first, x.first_row);
      if (pre > 0)
        chk("R11", $sformatf("vec %0d row before window", v), m_prerow, int'(x.shift) + 1);
    end

    // R8: mid-frame change leaves the running frame alone
    begin
      int maxl;
      mode_sel = 2'd1; pal_sel = 1'b0; shift_sel = 8'd3;
      do @(negedge clk); while (!(pix_cnt == 1 && line_cnt == 1));
      repeat (40) @(negedge clk);
      mode_sel = 2'd2; shift_sel = 8'd7;
      maxl = 0;
      do begin
        if (int'(line_cnt) > maxl) maxl = int'(line_cnt);
        if (shift_lines != 8'd3 || mode_active != 2'd1) maxl = 99;
        @(negedge clk);
      end while (!(pix_cnt == 1 && line_cnt == 1));
      chk("R8", "running frame kept fast-mode length and shift", maxl, 9);
      chk("R8", "new config after boundary", {mode_active, shift_lines}, {2'd2, 8'd7});
    end

    // R1: reset in mid frame
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid-frame reset counters", {int'(pix_cnt), int'(line_cnt)} , {32'd1, 32'd1});
    chk("R1", "mid-frame reset config", {mode_active, pal_active, shift_lines}, 0);
    rst_n = 1'b1;
    measure(-1);
    chk("R1", "frame after reset clocks", m_clocks, 312);

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule